// File: doc/BRIEF.md
# Hybrid Sequential-Combinational Polar Code Decoder

This block decodes one polar codeword of `BLK_LEN` channel LLRs by successive cancellation. The trellis stages above the component level run in a small sequential controller. Each component code of length `COMP_LEN` is handed to a single shared combinational decoder. The controller works through the components in natural order. For each one it derives the component's LLRs from the channel values and the registered partial sums, one upper stage per cycle. It then loads those LLRs into the input register of the combinational decoder, together with that component's slice of the information mask. It allows a programmed number of settle cycles and captures the `COMP_LEN` decisions. Finally it refreshes the partial sums for the next component. The combinational decoder is programmed only through the mask, so one instance serves every component, and any code rate can be chosen per codeword.

A codeword enters over a valid/ready handshake. `in_ready` is high while the decoder is idle and during the cycle of its completion pulse. It is low for the whole decode, so an upstream source is held off and must keep `in_valid` and its data until a cycle with both high. The result side has no back-pressure. `done` pulses for one cycle and `dec_bits` carries the decision vector from that cycle until the first capture of the next codeword. The configuration needs `BLK_LEN/COMP_LEN >= 2`, both powers of two, `COMP_LEN >= 2` and `SETTLE_CYC >= 1`.

Top module: `polar_hybrid_dec`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0 and `dec_bits` is 0.
- R2: A codeword (`in_llr`, `in_frozen`) is accepted in a clock cycle where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` stays 0 until the completion pulse, and `in_valid` and the input data have no effect during that time.
- R3: `dec_bits` equals a successive-cancellation decode in natural bit order. LLR element i is two's complement at `in_llr[i*LLR_W +: LLR_W]`, and an input of -2^(LLR_W-1) is taken as -(2^(LLR_W-1)-1). Each stage maps a vector of length m to m/2 entries using pairs (l[2j], l[2j+1]). Here f = sign(a)·sign(b)·min(|a|,|b|) and g = b + a when v_j = 0, or b − a when v_j = 1, saturated to ±(2^(LLR_W-1)−1). The partial sums are v_j = XOR of u_k over the left-half decisions k whose index bits contain j's bits. Bit u_i is 1 exactly when its final LLR is negative (zero gives 0) and the bit is an information bit.
- R4: `in_frozen` bit i = 1 marks bit i as an information bit and 0 as frozen. Every frozen position of `dec_bits` is 0, and bit i of `dec_bits` is u_i.
- R5: `done` is a one-cycle pulse exactly NUM_COMP·(log2(NUM_COMP)+3+SETTLE_CYC)+1 cycles after the acceptance cycle, where NUM_COMP = BLK_LEN/COMP_LEN. With the defaults this is 13 cycles.
- R6: `dec_bits` never changes in the cycle after one in which `in_ready` is 1. The result therefore holds from `done` through any idle time.
- R7: `in_ready` is 1 during the `done` cycle, so the next codeword can be accepted in the same cycle as the completion pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Codeword offered on `in_llr`/`in_frozen` |
| in_ready | output | 1 | Decoder can take a codeword this cycle |
| in_llr | input | BLK_LEN*LLR_W | Channel LLRs, element i at bits i*LLR_W upward |
| in_frozen | input | BLK_LEN | Information mask, bit i = 1 for an information bit |
| done | output | 1 | One-cycle pulse when all components are decoded |
| dec_bits | output | BLK_LEN | Decision vector, bit i = u_i |

## Verification
The completion pulse of one codeword and the acceptance of the next can fall in the same cycle. The bench provokes this by presenting each following codeword while the decoder is still busy and keeping `in_valid` high, so the handshake completes in the `done` cycle. It also changes the offered LLRs during the busy window. It judges the result with a behavioural model that predicts `in_ready` and `done` on every clock and the bit-exact decision vector at each pulse. So a codeword taken at the pulse must neither corrupt the vector being reported nor shift the following pulse.

// File: rtl/polar_hyb_pkg.sv
`timescale 1ns/1ps
package polar_hyb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAGE_CALC,
    ST_LOAD,
    ST_WAIT,
    ST_CAPTURE,
    ST_PSUM_UPDATE,
    ST_DONE
  } hyb_state_e;

endpackage

// File: rtl/polar_fg_unit.sv
`timescale 1ns/1ps
// One node of the decoding trellis: min-sum check update or saturating
// bit update, chosen by use_g.
module polar_fg_unit #(
  parameter int W = 6
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         psum,
  input  logic         use_g,
  output logic [W-1:0] y
);

  localparam int MAXV = 2 ** (W - 1) - 1;
  localparam logic signed [W:0] HI = (W + 1)'(MAXV);
  localparam logic signed [W:0] LO = -HI;

  logic [W-1:0] mag_a, mag_b, mag_min, f_val, g_val;
  logic signed [W:0] ax, bx, addend, sum;

  always_comb begin
    mag_a   = a[W-1] ? (~a + 1'b1) : a;
    mag_b   = b[W-1] ? (~b + 1'b1) : b;
    mag_min = (mag_a < mag_b) ? mag_a : mag_b;
    f_val   = (a[W-1] ^ b[W-1]) ? (~mag_min + 1'b1) : mag_min;

    ax     = $signed({a[W-1], a});
    bx     = $signed({b[W-1], b});
    addend = psum ? -ax : ax;
    sum    = bx + addend;
    if (sum > HI)      g_val = HI[W-1:0];
    else if (sum < LO) g_val = LO[W-1:0];
    else               g_val = sum[W-1:0];

    y = use_g ? g_val : f_val;
  end

endmodule

// File: rtl/polar_encoder.sv
`timescale 1ns/1ps
// Polar transform in natural order: x[j] is the XOR of u[k] over all k
// whose set bits include those of j.
module polar_encoder #(
  parameter int LEN = 2
) (
  input  logic [LEN-1:0] u,
  output logic [LEN-1:0] x
);

  always_comb begin
    for (int j = 0; j < LEN; j++) begin
      x[j] = 1'b0;
      for (int k = 0; k < LEN; k++) begin
        if ((k & j) == j) x[j] = x[j] ^ u[k];
      end
    end
  end

endmodule

// File: rtl/polar_comb_dec.sv
`timescale 1ns/1ps
// Purely combinational SC decoder for one component, built by recursion
// on the length; the information mask selects the code.
module polar_comb_dec #(
  parameter int W   = 6,
  parameter int LEN = 4
) (
  input  logic [LEN*W-1:0] llr,
  input  logic [LEN-1:0]   info,
  output logic [LEN-1:0]   u
);

  localparam int HALF = LEN / 2;

  generate
    if (LEN == 2) begin : g_leaf
      logic [W-1:0] f_llr, g_llr;
      logic         u0, u1;

      polar_fg_unit #(.W(W)) u_f (
        .a(llr[0 +: W]), .b(llr[W +: W]), .psum(1'b0), .use_g(1'b0), .y(f_llr)
      );
      assign u0 = info[0] & f_llr[W-1];

      polar_fg_unit #(.W(W)) u_g (
        .a(llr[0 +: W]), .b(llr[W +: W]), .psum(u0), .use_g(1'b1), .y(g_llr)
      );
      assign u1 = info[1] & g_llr[W-1];

      assign u = {u1, u0};
    end else begin : g_node
      logic [HALF*W-1:0] f_vec, g_vec;
      logic [HALF-1:0]   u_lo, u_hi, part;

      for (genvar j = 0; j < HALF; j++) begin : g_pair
        polar_fg_unit #(.W(W)) u_f (
          .a(llr[(2*j)*W +: W]), .b(llr[(2*j+1)*W +: W]),
          .psum(1'b0), .use_g(1'b0), .y(f_vec[j*W +: W])
        );
        polar_fg_unit #(.W(W)) u_g (
          .a(llr[(2*j)*W +: W]), .b(llr[(2*j+1)*W +: W]),
          .psum(part[j]), .use_g(1'b1), .y(g_vec[j*W +: W])
        );
      end

      polar_comb_dec #(.W(W), .LEN(HALF)) u_lo_dec (
        .llr(f_vec), .info(info[HALF-1:0]), .u(u_lo)
      );

      polar_encoder #(.LEN(HALF)) u_enc (
        .u(u_lo), .x(part)
      );

      polar_comb_dec #(.W(W), .LEN(HALF)) u_hi_dec (
        .llr(g_vec), .info(info[LEN-1:HALF]), .u(u_hi)
      );

      assign u = {u_hi, u_lo};
    end
  endgenerate

endmodule

// File: rtl/polar_hybrid_dec.sv
`timescale 1ns/1ps
module polar_hybrid_dec
  import polar_hyb_pkg::*;
#(
  parameter int BLK_LEN    = 8,
  parameter int COMP_LEN   = 4,
  parameter int LLR_W      = 6,
  parameter int SETTLE_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [BLK_LEN*LLR_W-1:0] in_llr,
  input  logic [BLK_LEN-1:0]       in_frozen,
  output logic                     done,
  output logic [BLK_LEN-1:0]       dec_bits
);

  localparam int NUM_COMP  = BLK_LEN / COMP_LEN;
  localparam int UP_STAGES = $clog2(NUM_COMP);
  localparam int LOG_BLK   = $clog2(BLK_LEN);
  localparam int HALF_BLK  = BLK_LEN / 2;
  localparam int CI_W      = (UP_STAGES > 0) ? UP_STAGES : 1;
  localparam int STG_W     = (UP_STAGES > 1) ? $clog2(UP_STAGES) : 1;
  localparam int WC_W      = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [LLR_W-1:0] MOST_NEG = {1'b1, {(LLR_W-1){1'b0}}};
  localparam logic [LLR_W-1:0] NEG_MAX  = MOST_NEG + 1'b1;

  hyb_state_e state_q;

  logic [LLR_W-1:0]      ch_q    [BLK_LEN];
  logic [LLR_W-1:0]      work_q  [HALF_BLK];
  logic [HALF_BLK-1:0]   psum_q  [UP_STAGES];
  logic [HALF_BLK-1:0]   psum_n  [UP_STAGES];
  logic [BLK_LEN-1:0]    info_q;
  logic [BLK_LEN-1:0]    uhat_q;
  logic [CI_W-1:0]       ci_q, nxt_ci;
  logic [STG_W-1:0]      stg_q;
  logic [WC_W-1:0]       wcnt_q;
  logic [COMP_LEN*LLR_W-1:0] cd_llr_q;
  logic [COMP_LEN-1:0]   cd_info_q;
  logic [COMP_LEN-1:0]   cd_u;
  logic [COMP_LEN-1:0]   info_slice;

  logic [LLR_W-1:0]      src     [BLK_LEN];
  logic [LLR_W-1:0]      stage_y [HALF_BLK];
  logic [HALF_BLK-1:0]   psel;
  logic                  cur_bit;
  logic                  accept;

  assign in_ready = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign done     = (state_q == ST_DONE);
  assign dec_bits = uhat_q;
  assign accept   = in_valid && in_ready;
  assign nxt_ci   = ci_q + 1'b1;

  // Source vector of the current upper stage: channel values at the top,
  // the previous stage's output below.
  always_comb begin
    for (int k = 0; k < HALF_BLK; k++)
      src[k] = (stg_q == '0) ? ch_q[k] : work_q[k];
    for (int k = HALF_BLK; k < BLK_LEN; k++)
      src[k] = (stg_q == '0) ? ch_q[k] : '0;
  end

  // Branch bit and partial sums for the stage being computed.
  always_comb begin
    cur_bit = 1'b0;
    psel    = '0;
    for (int d = 0; d < UP_STAGES; d++) begin
      if (stg_q == STG_W'(d)) begin
        cur_bit = ci_q[UP_STAGES-1-d];
        psel    = psum_q[d];
      end
    end
  end

  for (genvar j = 0; j < HALF_BLK; j++) begin : g_up
    polar_fg_unit #(.W(LLR_W)) u_fg (
      .a(src[2*j]), .b(src[2*j+1]), .psum(psel[j]), .use_g(cur_bit),
      .y(stage_y[j])
    );
  end

  // Partial sums of every upper stage for the next component: the polar
  // transform of the left sibling's decisions at that stage.
  always_comb begin
    int base;
    int len;
    logic acc;
    logic [LOG_BLK-1:0] pos;
    for (int d = 0; d < UP_STAGES; d++) begin
      len  = BLK_LEN >> (d + 1);
      base = int'(nxt_ci >> (UP_STAGES - d)) << (LOG_BLK - d);
      for (int j = 0; j < HALF_BLK; j++) begin
        acc = 1'b0;
        for (int k = 0; k < HALF_BLK; k++) begin
          if (j < len && k < len && ((k & j) == j)) begin
            pos = LOG_BLK'(base + k);
            acc = acc ^ uhat_q[pos];
          end
        end
        psum_n[d][j] = acc;
      end
    end
  end

  always_comb begin
    info_slice = '0;
    for (int c = 0; c < NUM_COMP; c++)
      if (ci_q == CI_W'(c)) info_slice = info_q[c*COMP_LEN +: COMP_LEN];
  end

  polar_comb_dec #(.W(LLR_W), .LEN(COMP_LEN)) u_cdec (
    .llr(cd_llr_q), .info(cd_info_q), .u(cd_u)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      info_q    <= '0;
      uhat_q    <= '0;
      ci_q      <= '0;
      stg_q     <= '0;
      wcnt_q    <= '0;
      cd_llr_q  <= '0;
      cd_info_q <= '0;
      for (int k = 0; k < BLK_LEN; k++)   ch_q[k]   <= '0;
      for (int k = 0; k < HALF_BLK; k++)  work_q[k] <= '0;
      for (int d = 0; d < UP_STAGES; d++) psum_q[d] <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            for (int k = 0; k < BLK_LEN; k++) begin
              ch_q[k] <= (in_llr[k*LLR_W +: LLR_W] == MOST_NEG) ?
                         NEG_MAX : in_llr[k*LLR_W +: LLR_W];
            end
            info_q  <= in_frozen;
            ci_q    <= '0;
            stg_q   <= '0;
            state_q <= ST_STAGE_CALC;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_STAGE_CALC: begin
          for (int j = 0; j < HALF_BLK; j++) work_q[j] <= stage_y[j];
          if (stg_q == STG_W'(UP_STAGES - 1)) begin
            stg_q   <= '0;
            state_q <= ST_LOAD;
          end else begin
            stg_q <= stg_q + 1'b1;
          end
        end
        ST_LOAD: begin
          for (int k = 0; k < COMP_LEN; k++) cd_llr_q[k*LLR_W +: LLR_W] <= work_q[k];
          cd_info_q <= info_slice;
          wcnt_q    <= '0;
          state_q   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wcnt_q == WC_W'(SETTLE_CYC - 1)) state_q <= ST_CAPTURE;
          else                                 wcnt_q  <= wcnt_q + 1'b1;
        end
        ST_CAPTURE: begin
          for (int c = 0; c < NUM_COMP; c++)
            if (ci_q == CI_W'(c)) uhat_q[c*COMP_LEN +: COMP_LEN] <= cd_u;
          state_q <= ST_PSUM_UPDATE;
        end
        ST_PSUM_UPDATE: begin
          if (ci_q == CI_W'(NUM_COMP - 1)) begin
            state_q <= ST_DONE;
          end else begin
            ci_q <= nxt_ci;
            for (int d = 0; d < UP_STAGES; d++) psum_q[d] <= psum_n[d];
            stg_q   <= '0;
            state_q <= ST_STAGE_CALC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/polar_hybrid_dec_chk.sv
`timescale 1ns/1ps
module polar_hybrid_dec_chk #(
  parameter int BLK_LEN    = 8,
  parameter int COMP_LEN   = 4,
  parameter int LLR_W      = 6,
  parameter int SETTLE_CYC = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [BLK_LEN-1:0] in_frozen,
  input logic               done,
  input logic [BLK_LEN-1:0] dec_bits
);

  localparam int NUM_COMP  = BLK_LEN / COMP_LEN;
  localparam int UP_STAGES = $clog2(NUM_COMP);
  localparam int LAT       = NUM_COMP * (UP_STAGES + 3 + SETTLE_CYC);

  logic [BLK_LEN-1:0] mask_q;
  int unsigned        since_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      since_q <= 0;
    end else if (in_valid && in_ready) begin
      mask_q  <= in_frozen;
      since_q <= 1;
    end else if (done) begin
      since_q <= 0;
    end else if (since_q != 0) begin
      since_q <= since_q + 1;
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_frozen_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((dec_bits & ~mask_q) == '0));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_q == LAT + 1));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> $stable(dec_bits));

  p_ready_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

endmodule

bind polar_hybrid_dec polar_hybrid_dec_chk #(
  .BLK_LEN(BLK_LEN), .COMP_LEN(COMP_LEN), .LLR_W(LLR_W), .SETTLE_CYC(SETTLE_CYC)
) chk_i (.*);

// File: tb/polar_hybrid_dec_tb_top.sv
`timescale 1ns/1ps
module polar_hybrid_dec_tb_top;

  localparam int N     = 8;
  localparam int NC    = 4;
  localparam int W     = 6;
  localparam int S     = 2;
  localparam int NCOMP = N / NC;
  localparam int L     = $clog2(NCOMP);
  localparam int LOGN  = $clog2(N);
  localparam int LAT   = NCOMP * (L + 3 + S);
  localparam int MAXV  = 2 ** (W - 1) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [N*W-1:0] in_llr;
  logic [N-1:0]   in_frozen;
  logic           done;
  logic [N-1:0]   dec_bits;

  int          drv_llr [N];
  logic [N-1:0] drv_fr = '0;

  int           n_cmp = 0;
  int           n_bad = 0;
  int           cyc = 0;
  int           m_cnt = 0;
  logic [N-1:0] m_exp = '0;
  logic [N-1:0] last_exp = '0;
  bit           have_res = 0;
  bit           live = 0;
  logic [31:0]  seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) in_llr[k*W +: W] = W'(drv_llr[k]);
    in_frozen = drv_fr;
  end

  polar_hybrid_dec #(.BLK_LEN(N), .COMP_LEN(NC), .LLR_W(W), .SETTLE_CYC(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_llr(in_llr), .in_frozen(in_frozen), .done(done), .dec_bits(dec_bits)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > MAXV)  return MAXV;
    if (v < -MAXV) return -MAXV;
    return v;
  endfunction

  function automatic int fmin(input int a, input int b);
    int ma, mb, m;
    ma = (a < 0) ? -a : a;
    mb = (b < 0) ? -b : b;
    m  = (ma < mb) ? ma : mb;
    return ((a < 0) != (b < 0)) ? -m : m;
  endfunction

  function automatic int gsum(input int a, input int b, input bit v);
    return sat(v ? b - a : b + a);
  endfunction

  // Successive cancellation, bit by bit, descending the full tree each time.
  function automatic logic [N-1:0] ref_decode(input int ch [N], input logic [N-1:0] info);
    logic [N-1:0] u;
    int vec [N];
    int nv  [N];
    bit ps  [N];
    int m, half, start;
    bit br;
    u = '0;
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < N; k++) vec[k] = (ch[k] < -MAXV) ? -MAXV : ch[k];
      m = N;
      for (int d = 0; d < LOGN; d++) begin
        br    = ((i >> (LOGN - 1 - d)) & 1) != 0;
        start = (i >> (LOGN - d)) << (LOGN - d);
        half  = m / 2;
        for (int k = 0; k < N; k++) ps[k] = 0;
        if (br) begin
          for (int k = 0; k < half; k++) ps[k] = u[start + k];
          for (int s = 1; s < half; s = s * 2)
            for (int j = 0; j < half; j++)
              if ((j & s) == 0) ps[j] = ps[j] ^ ps[j + s];
        end
        for (int j = 0; j < half; j++)
          nv[j] = br ? gsum(vec[2*j], vec[2*j+1], ps[j]) : fmin(vec[2*j], vec[2*j+1]);
        for (int j = 0; j < half; j++) vec[j] = nv[j];
        m = half;
      end
      u[i] = info[i] && (vec[0] < 0);
    end
    return u;
  endfunction

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 64) - 32;
  endfunction

  // Behavioural model of the handshake, the completion timing and the result.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0;
    end else if (in_valid && m_cnt <= 1) begin
      m_exp = ref_decode(drv_llr, drv_fr);
      m_cnt = LAT + 1;
    end else if (m_cnt > 0) begin
      m_cnt--;
    end
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk(in_ready == (m_cnt <= 1), (m_cnt == 1) ? "R7 ready at done" : "R2 ready",
          64'(in_ready), 64'(m_cnt <= 1));
      chk(done == (m_cnt == 1), "R5 done timing", 64'(done), 64'(m_cnt == 1));
      if (m_cnt == 1) begin
        chk(dec_bits == m_exp, "R3 R4 decisions", 64'(dec_bits), 64'(m_exp));
        last_exp = m_exp;
        have_res = 1;
      end else if (m_cnt == 0 && have_res) begin
        chk(dec_bits == last_exp, "R6 hold", 64'(dec_bits), 64'(last_exp));
      end
    end
  end

  // Called at a negedge; holds in_valid until the model is ready.
  task automatic send(input logic [N-1:0] fr);
    drv_fr   = fr;
    in_valid = 1'b1;
    while (!(m_cnt <= 1)) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    while (m_cnt != 0) @(negedge clk);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] uw;
    bit xb [N];
    for (int k = 0; k < N; k++) drv_llr[k] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready", 64'(in_ready), 64'd1);
    chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
    chk(dec_bits == '0, "R1 bits", 64'(dec_bits), 64'd0);
    live = 1;

    // R3: strong positive LLRs, every bit information -> all zero
    for (int k = 0; k < N; k++) drv_llr[k] = 20;
    send('1);
    idle_wait(3);

    // R4: mask 11101000 (bits 3,5,6,7 information), mixed LLRs
    drv_llr = '{-7, 3, -12, 5, 9, -2, -14, 6};
    send(8'b1110_1000);
    idle_wait(2);

    // R3: noiseless codeword of u = B5, all information bits
    uw = 8'hB5;
    for (int k = 0; k < N; k++) xb[k] = uw[k];
    for (int s = 1; s < N; s = s * 2)
      for (int j = 0; j < N; j++)
        if ((j & s) == 0) xb[j] = xb[j] ^ xb[j + s];
    for (int k = 0; k < N; k++) drv_llr[k] = xb[k] ? -9 : 9;
    send('1);
    idle_wait(2);

    // R3: saturation and the most negative input code
    drv_llr = '{-32, 31, -31, -32, 31, 31, -32, 30};
    send('1);
    idle_wait(1);

    // R4: all bits frozen -> zero despite negative LLRs
    for (int k = 0; k < N; k++) drv_llr[k] = -11;
    send('0);
    idle_wait(1);

    // R3: zero LLRs decide 0
    for (int k = 0; k < N; k++) drv_llr[k] = 0;
    send('1);
    idle_wait(1);

    // R2 R7: back-to-back random codewords, next one offered while busy
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < N; k++) drv_llr[k] = rnd();
      send(N'(rnd()) | N'(t & 1 ? 8'h88 : 8'h00));
    end
    idle_wait(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule